// File: doc/BRIEF.md
# Postfix Stack Evaluator

This block runs a stream of zero-operand instructions to evaluate arithmetic expressions written in reverse Polish (postfix) order. It has a variable register file. A PUSH instruction copies one variable onto a last-in, first-out operand stack. A POP instruction moves the top entry back into a variable. An arithmetic instruction (ADD, SUB, MUL) replaces the two topmost entries with their result. Every instruction takes one clock cycle. The stack pointer stays inside the block. The outputs show only whether the stack is empty or full, the value on top of the stack, a sticky error flag, and a one-cycle done pulse after each POP.

A host first loads operand values through the variable write port. It then issues the instruction sequence for an expression, for example PUSH X, PUSH Y, MUL, PUSH W, PUSH U, MUL, ADD, POP Z. It collects the result through the variable read port. The data width, stack depth and number of variables are parameters.

The control is a two-state machine. ST_RUN executes instructions. ST_FAULT ignores every instruction until reset. There are two transitions: a reset entry into ST_RUN, and ST_RUN to ST_FAULT, taken on an instruction that cannot execute. ST_FAULT is left only by reset.

Top module: `rpn_stack_engine`

## Requirements
- R1: After reset, `stack_empty` is 1 and `stack_full`, `error`, `done` and `tos_data` are 0. Every variable reads 0.
- R2: A PUSH (opcode 3'd0) with `instr_valid` high copies the variable selected by `instr_var` onto the stack. `tos_data` shows that value in the cycle after the clock edge.
- R3: Entries leave the stack in the reverse of the order they were pushed.
- R4: ADD (opcode 3'd2) removes the two top entries and pushes their sum modulo 2^WIDTH. The stack shrinks by one entry.
- R5: SUB (opcode 3'd3) pushes (entry below the top) minus (top entry), modulo 2^WIDTH.
- R6: MUL (opcode 3'd4) pushes the low WIDTH bits of the product of the two top entries.
- R7: POP (opcode 3'd1) writes the top entry into the variable selected by `instr_var` and removes that entry. `done` is high for exactly the one cycle after each executed POP and is low at all other times.
- R8: `stack_empty` is high exactly when the stack holds no entries. `stack_full` is high exactly when it holds DEPTH entries. `tos_data` is 0 when the stack is empty.
- R9: Three instructions raise `error` and change neither the stack nor any variable: an arithmetic instruction with fewer than two entries on the stack, a POP on an empty stack, and a PUSH on a full stack.
- R10: Once `error` is set, it stays set and every later instruction is ignored until reset.
- R11: Opcodes 3'd5 to 3'd7, and any cycle with `instr_valid` low, have no effect on the stack, the variables or the flags.
- R12: The host write port updates a variable at the clock edge, in either state. When a POP writes the same variable in the same cycle, the POP value wins. A PUSH in that cycle reads the value held before the edge.
- R13: The sequence PUSH X, PUSH Y, MUL, PUSH W, PUSH U, MUL, ADD, POP Z leaves X·Y + W·U (modulo 2^WIDTH) in Z and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_op | input | 3 | Opcode: PUSH 0, POP 1, ADD 2, SUB 3, MUL 4 |
| instr_var | input | $clog2(NVARS) | Variable index for PUSH or POP |
| var_wr_en | input | 1 | Host variable write enable |
| var_wr_idx | input | $clog2(NVARS) | Host write index |
| var_wr_data | input | WIDTH | Host write data |
| var_rd_idx | input | $clog2(NVARS) | Host read index |
| var_rd_data | output | WIDTH | Selected variable value |
| tos_data | output | WIDTH | Top-of-stack value, 0 when empty |
| stack_empty | output | 1 | Stack holds no entries |
| stack_full | output | 1 | Stack holds DEPTH entries |
| error | output | 1 | Sticky fault flag |
| done | output | 1 | One-cycle pulse after a POP |

## Verification
The bench builds the block with WIDTH=8, DEPTH=4 and NVARS=4. An 8-bit width makes sums and products wrap often, and subtraction below zero wraps at once. A four-entry stack puts the full and empty boundaries, and both overflow faults, within a few instructions. Random streams can then hit them many times. Four variables make it likely that a host write and a POP land on the same variable in the same cycle, which exercises the write priority.

// File: rtl/rpn_pkg.sv
package rpn_pkg;
    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4
    } rpn_op_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } rpn_state_e;
endpackage

// File: rtl/rpn_alu.sv
module rpn_alu #(
    parameter int WIDTH = 16
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] res
);
    import rpn_pkg::*;

    always_comb begin
        case (op)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_MUL:  res = lhs * rhs;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/rpn_lifo.sv
module rpn_lifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pop_n,
    input  logic             push_en,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] below,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] slots [DEPTH];
    logic [CW-1:0]    base;
    logic [CW-1:0]    top_ix;
    logic [CW-1:0]    below_ix;

    assign base     = count - CW'(pop_n);
    assign top_ix   = count - CW'(1);
    assign below_ix = count - CW'(2);
    assign top      = (count != '0)     ? slots[top_ix[AW-1:0]]   : '0;
    assign below    = (count >= CW'(2)) ? slots[below_ix[AW-1:0]] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= base + CW'(push_en);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slots[g] <= '0;
                end else if (push_en && base == CW'(g)) begin
                    slots[g] <= push_data;
                end
            end
        end
    endgenerate

    // R8: the pointer never passes the stack depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9: the controller never removes more entries than are held
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= count);
    // R9: a plain push is only issued with room left
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_n == 2'd0) |-> (count < CW'(DEPTH)));
endmodule

// File: rtl/rpn_varfile.sv
module rpn_varfile #(
    parameter int WIDTH = 16,
    parameter int NVARS = 8,
    localparam int AW = (NVARS > 1) ? $clog2(NVARS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [AW-1:0]    host_idx,
    input  logic [WIDTH-1:0] host_data,
    input  logic             core_we,
    input  logic [AW-1:0]    core_idx,
    input  logic [WIDTH-1:0] core_data,
    input  logic [AW-1:0]    rd_a_idx,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [AW-1:0]    rd_b_idx,
    output logic [WIDTH-1:0] rd_b_data
);
    logic [WIDTH-1:0] cells [NVARS];

    assign rd_a_data = cells[rd_a_idx];
    assign rd_b_data = cells[rd_b_idx];

    generate
        for (genvar g = 0; g < NVARS; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[g] <= '0;
                end else if (core_we && core_idx == AW'(g)) begin
                    cells[g] <= core_data;
                end else if (host_we && host_idx == AW'(g)) begin
                    cells[g] <= host_data;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rpn_stack_engine.sv
module rpn_stack_engine #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    parameter int NVARS = 8,
    localparam int VAW = (NVARS > 1) ? $clog2(NVARS) : 1,
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [2:0]       instr_op,
    input  logic [VAW-1:0]   instr_var,
    input  logic             var_wr_en,
    input  logic [VAW-1:0]   var_wr_idx,
    input  logic [WIDTH-1:0] var_wr_data,
    input  logic [VAW-1:0]   var_rd_idx,
    output logic [WIDTH-1:0] var_rd_data,
    output logic [WIDTH-1:0] tos_data,
    output logic             stack_empty,
    output logic             stack_full,
    output logic             error,
    output logic             done
);
    import rpn_pkg::*;

    rpn_state_e       state, state_nx;
    logic             accept, is_push, is_pop, is_bin, legal, fault_now;
    logic [1:0]       pop_n;
    logic             push_en;
    logic [WIDTH-1:0] push_data, top_val, below_val, alu_res, src_val;
    logic [CW-1:0]    stk_count;

    assign accept = instr_valid && (state == ST_RUN);

    always_comb begin
        is_push = 1'b0;
        is_pop  = 1'b0;
        is_bin  = 1'b0;
        case (instr_op)
            OP_PUSH:                is_push = 1'b1;
            OP_POP:                 is_pop  = 1'b1;
            OP_ADD, OP_SUB, OP_MUL: is_bin  = 1'b1;
            default: ;
        endcase
    end

    assign legal = (is_push && stk_count < CW'(DEPTH))
                || (is_pop  && stk_count != '0)
                || (is_bin  && stk_count >= CW'(2));
    assign fault_now = accept && (is_push || is_pop || is_bin) && !legal;

    always_comb begin
        pop_n   = 2'd0;
        push_en = 1'b0;
        if (accept && legal) begin
            if (is_push) begin
                push_en = 1'b1;
            end else if (is_pop) begin
                pop_n = 2'd1;
            end else begin
                pop_n   = 2'd2;
                push_en = 1'b1;
            end
        end
    end

    assign push_data = is_push ? src_val : alu_res;

    rpn_alu #(.WIDTH(WIDTH)) u_alu (
        .op (instr_op),
        .lhs(below_val),
        .rhs(top_val),
        .res(alu_res)
    );

    rpn_lifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_n    (pop_n),
        .push_en  (push_en),
        .push_data(push_data),
        .top      (top_val),
        .below    (below_val),
        .count    (stk_count)
    );

    rpn_varfile #(.WIDTH(WIDTH), .NVARS(NVARS)) u_vars (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_we  (var_wr_en),
        .host_idx (var_wr_idx),
        .host_data(var_wr_data),
        .core_we  (accept && legal && is_pop),
        .core_idx (instr_var),
        .core_data(top_val),
        .rd_a_idx (instr_var),
        .rd_a_data(src_val),
        .rd_b_idx (var_rd_idx),
        .rd_b_data(var_rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (fault_now) state_nx = ST_FAULT;
            ST_FAULT: state_nx = ST_FAULT;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= accept && legal && is_pop;
    end

    assign error       = (state == ST_FAULT);
    assign stack_empty = (stk_count == '0);
    assign stack_full  = (stk_count == CW'(DEPTH));
    assign tos_data    = top_val;

    // R10: fault is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
    // R9 R10: no stack movement while faulted
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> $stable(stk_count));
    // R7: a done pulse follows a one-entry shrink of the stack
    a_r7_done_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (stk_count == $past(stk_count) - CW'(1)));
    // R4: an executed operator leaves one entry fewer
    a_r4_bin_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_bin && legal) |=> (stk_count == $past(stk_count) - CW'(1)));
    // R8: empty and full are exclusive
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(stack_empty && stack_full));
endmodule

// File: tb/rpn_stack_engine_test.sv
module rpn_stack_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int D  = 4;
    localparam int NV = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [2:0]   instr_op = '0;
    logic [1:0]   instr_var = '0;
    logic         var_wr_en = 1'b0;
    logic [1:0]   var_wr_idx = '0;
    logic [W-1:0] var_wr_data = '0;
    logic [1:0]   var_rd_idx = '0;
    logic [W-1:0] var_rd_data, tos_data;
    logic         stack_empty, stack_full, error, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [W-1:0] m_stk [D];
    logic [W-1:0] m_vars [NV];
    int           m_cnt;
    bit           m_err;
    bit           m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpn_stack_engine #(.WIDTH(W), .DEPTH(D), .NVARS(NV)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_var(instr_var), .var_wr_en(var_wr_en), .var_wr_idx(var_wr_idx),
        .var_wr_data(var_wr_data), .var_rd_idx(var_rd_idx), .var_rd_data(var_rd_data),
        .tos_data(tos_data), .stack_empty(stack_empty), .stack_full(stack_full),
        .error(error), .done(done)
    );

    function automatic logic [W-1:0] f_alu(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [2*W-1:0] p;
        p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        case (op)
            3'd2:    return a + b;
            3'd3:    return a - b;
            3'd4:    return p[W-1:0];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk(tag, 32'(tos_data), (m_cnt > 0) ? 32'(m_stk[m_cnt-1]) : 32'd0);
        chk("R8 empty", 32'(stack_empty), 32'(m_cnt == 0));
        chk("R8 full", 32'(stack_full), 32'(m_cnt == D));
        chk("R10 error", 32'(error), 32'(m_err));
        chk("R7 done", 32'(done), 32'(m_done));
        var_rd_idx = 2'($urandom % NV);
        #1;
        chk("R12 variable", 32'(var_rd_data), 32'(m_vars[var_rd_idx]));
    endtask

    task automatic read_var(input logic [1:0] idx, input string req, input logic [W-1:0] exp);
        var_rd_idx = idx;
        #1;
        chk(req, 32'(var_rd_data), 32'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        var_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0;
        m_err = 0;
        m_done = 0;
        for (int i = 0; i < D; i++) m_stk[i] = '0;
        for (int i = 0; i < NV; i++) m_vars[i] = '0;
    endtask

    task automatic exec(input bit v, input logic [2:0] op, input logic [1:0] idx,
                        input bit we, input logic [1:0] widx, input logic [W-1:0] wdata,
                        input string tag);
        logic [W-1:0] pop_val;
        bit pop_w;
        pop_w = 0;
        pop_val = '0;
        @(negedge clk);
        instr_valid = v;
        instr_op = op;
        instr_var = idx;
        var_wr_en = we;
        var_wr_idx = widx;
        var_wr_data = wdata;
        m_done = 0;
        if (v && !m_err) begin
            case (op)
                3'd0: if (m_cnt == D) m_err = 1;
                      else begin m_stk[m_cnt] = m_vars[idx]; m_cnt++; end
                3'd1: if (m_cnt == 0) m_err = 1;
                      else begin pop_val = m_stk[m_cnt-1]; m_cnt--; pop_w = 1; m_done = 1; end
                3'd2, 3'd3, 3'd4:
                      if (m_cnt < 2) m_err = 1;
                      else begin
                          m_stk[m_cnt-2] = f_alu(op, m_stk[m_cnt-2], m_stk[m_cnt-1]);
                          m_cnt--;
                      end
                default: ;
            endcase
        end
        if (we) m_vars[widx] = wdata;
        if (pop_w) m_vars[idx] = pop_val;
        @(negedge clk);
        instr_valid = 1'b0;
        var_wr_en = 1'b0;
        check_outputs(tag);
    endtask

    task automatic load(input logic [1:0] idx, input logic [W-1:0] val);
        exec(1'b0, 3'd0, 2'd0, 1'b1, idx, val, "R12 load");
    endtask

    task automatic op(input logic [2:0] code, input logic [1:0] idx, input string tag);
        exec(1'b1, code, idx, 1'b0, 2'd0, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        do_reset();
        // R1 reset state
        chk("R1 empty", 32'(stack_empty), 32'd1);
        chk("R1 full", 32'(stack_full), 32'd0);
        chk("R1 error", 32'(error), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 tos", 32'(tos_data), 32'd0);
        for (int i = 0; i < NV; i++) read_var(2'(i), "R1 variable", '0);

        // R13 worked expression: 3*5 + 7*2 = 29
        load(2'd0, 8'd3); load(2'd1, 8'd5); load(2'd2, 8'd7); load(2'd3, 8'd2);
        op(3'd0, 2'd0, "R2 push");
        chk("R2 tos", 32'(tos_data), 32'd3);
        op(3'd0, 2'd1, "R2 push");
        op(3'd4, 2'd0, "R6 mul");
        op(3'd0, 2'd2, "R2 push");
        op(3'd0, 2'd3, "R2 push");
        op(3'd4, 2'd0, "R6 mul");
        op(3'd2, 2'd0, "R4 add");
        chk("R4 sum", 32'(tos_data), 32'd29);
        op(3'd1, 2'd0, "R13 pop");
        read_var(2'd0, "R13 result", 8'd29);
        chk("R13 empty", 32'(stack_empty), 32'd1);

        // R3 ordering: push 29,5,7 then pop three times
        op(3'd0, 2'd0, "R3"); op(3'd0, 2'd1, "R3"); op(3'd0, 2'd2, "R3");
        op(3'd1, 2'd3, "R3 pop"); read_var(2'd3, "R3 first out", 8'd7);
        op(3'd1, 2'd3, "R3 pop"); read_var(2'd3, "R3 second out", 8'd5);
        op(3'd1, 2'd3, "R3 pop"); read_var(2'd3, "R3 third out", 8'd29);

        // R5 subtraction order and wrap: 2 - 7 = 251
        load(2'd0, 8'd2); load(2'd1, 8'd7);
        op(3'd0, 2'd0, "R5"); op(3'd0, 2'd1, "R5");
        op(3'd3, 2'd0, "R5 sub");
        chk("R5 wrap", 32'(tos_data), 32'd251);
        // R6 product truncation: 20*20 = 400 -> 144
        load(2'd2, 8'd20);
        op(3'd1, 2'd3, "R7 pop");
        op(3'd0, 2'd2, "R6"); op(3'd0, 2'd2, "R6");
        op(3'd4, 2'd0, "R6 mul");
        chk("R6 low bits", 32'(tos_data), 32'd144);
        // R11 reserved opcodes and idle valid
        op(3'd5, 2'd0, "R11 reserved");
        op(3'd7, 2'd1, "R11 reserved");
        exec(1'b0, 3'd1, 2'd0, 1'b0, 2'd0, '0, "R11 idle");
        chk("R11 unchanged", 32'(tos_data), 32'd144);
        // R12 collision: host write and POP to same variable
        exec(1'b1, 3'd1, 2'd1, 1'b1, 2'd1, 8'd99, "R12 collide");
        read_var(2'd1, "R12 pop wins", 8'd144);

        // R9 overflow then R10 sticky
        do_reset();
        load(2'd0, 8'd11);
        for (int i = 0; i < D; i++) op(3'd0, 2'd0, "R8 fill");
        chk("R8 full at depth", 32'(stack_full), 32'd1);
        op(3'd0, 2'd0, "R9 push full");
        chk("R9 error set", 32'(error), 32'd1);
        op(3'd1, 2'd1, "R10 ignored pop");
        read_var(2'd1, "R10 var untouched", 8'd0);
        chk("R10 no done", 32'(done), 32'd0);
        // R9 underflow cases
        do_reset();
        op(3'd2, 2'd0, "R9 add empty");
        do_reset();
        op(3'd1, 2'd0, "R9 pop empty");
        do_reset();
        load(2'd0, 8'd4);
        op(3'd0, 2'd0, "R2 push");
        op(3'd3, 2'd0, "R9 sub one entry");
        chk("R9 kept entry", 32'(tos_data), 32'd4);

        // random streams
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [2:0] c;
            r = int'($urandom % 10);
            if (r < 4)       c = 3'd0;
            else if (r == 4) c = 3'd1;
            else if (r < 8)  c = 3'(r - 3);
            else             c = 3'(5 + ($urandom % 3));
            exec(($urandom % 8) != 0, c, 2'($urandom % NV), ($urandom % 4) == 0,
                 2'($urandom % NV), W'($urandom), "R2 R4 R5 R6 random tos");
            if (m_err && ($urandom % 4) == 0) do_reset();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule